// File: doc/BRIEF.md
# Channel Interrupt Status and Completion Accounting

This block is the interrupt register group of one DMA channel. Hardware event pulses from the channel (pause, transfer finished, bus errors on data and descriptor reads, byte-count overflow and per-side descriptor completion) latch into a 12-bit sticky status register. A 12-bit mask register, changed only through a pair of strobe registers, selects which latched bits may drive the single level interrupt line `irq`.

Two 8-bit counters record descriptor completions on the source and destination sides. Software reads a counter to collect and zero it in one access; a wrap of a counter is reported through its own accounting-error status bit. Any access to an unmapped offset is flagged in the status register instead of being silently dropped.

Software sees everything through a simple word-addressed register port: `reg_sel` with `reg_we` selects a write or a read, and read data is registered and appears on `reg_rdata` after the clock edge that accepts the read.

Top module: `irq_acct_regs`

## Requirements
- R1: After a synchronous active-low reset the status register reads 0x000, the mask reads 0xFFF, both counters read 0 and `irq` is low.
- R2: A write to the status register (offset 0) clears each status bit written with 1 and leaves bits written with 0 unchanged.
- R3: A write to the mask register (offset 1) leaves the mask unchanged; a read of offset 1 returns the mask.
- R4: A write to offset 2 clears the mask bits where the data holds 1s; a write to offset 3 sets them; reads of offsets 2 and 3 return 0.
- R5: `irq` is high exactly when some status bit is 1 and its mask bit is 0, from the clock edge that changed status or mask.
- R6: A source (destination) descriptor-done pulse increments the source (destination) counter and sets status bit 1 (bit 2); when the counter wraps from 255 to 0 status bit 4 (bit 5) is also set.
- R7: A read of offset 4 (source) or 5 (destination) returns the counter and zeroes it; a done pulse in the same cycle as the read leaves the counter at 1 and the read returns the old value.
- R8: An access to offset 6 or 7 sets status bit 0; such a read returns 0 and such a write changes no register.
- R9: When a hardware event and a write-one-to-clear hit the same status bit in one cycle, the bit ends set.
- R10: Event inputs map to status bits: pause 11, transfer done 10, write-data error 9, read-data error 8, destination-descriptor read error 7, source-descriptor read error 6, byte-count overflow 3.
- R11: `reg_rdata` holds the data of the last accepted read until the next read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access request for this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (3) | Word offset |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Registered read data |
| ev_pause | input | 1 | Channel paused event |
| ev_xfer_done | input | 1 | Transfer finished event |
| ev_wr_data_err | input | 1 | Write-data bus error event |
| ev_rd_data_err | input | 1 | Read-data bus error event |
| ev_dst_dscr_err | input | 1 | Destination descriptor read error event |
| ev_src_dscr_err | input | 1 | Source descriptor read error event |
| ev_byte_ovf | input | 1 | Byte-count overflow event |
| ev_src_dscr_done | input | 1 | Source descriptor completed |
| ev_dst_dscr_done | input | 1 | Destination descriptor completed |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can land in one cycle: a hardware event setting a status bit while software writes a 1 to clear that same bit, and a descriptor-done pulse arriving in the cycle a counter is read and cleared. The bench provokes both by holding the event input high across the register access, then judges the first by reading status back (the bit must remain set) and the second by reading the counter twice (old value, then 1). Counter wrap is driven with 256 back-to-back completions and judged through both the zeroed counter and the accounting-error bit.

// File: rtl/irq_acct_pkg.sv
// Package: register offsets and status bit positions shared by the
// interrupt/accounting register group and its checker.
package irq_acct_pkg;
    localparam int STAT_W = 12;

    // Status bit positions (also used by mask and strobe registers)
    localparam int B_INVALID   = 0;
    localparam int B_SRC_DONE  = 1;
    localparam int B_DST_DONE  = 2;
    localparam int B_BYTE_OVF  = 3;
    localparam int B_SRC_ACCT  = 4;
    localparam int B_DST_ACCT  = 5;
    localparam int B_SRC_DRD   = 6;
    localparam int B_DST_DRD   = 7;
    localparam int B_RD_DATA   = 8;
    localparam int B_WR_DATA   = 9;
    localparam int B_XFER_DONE = 10;
    localparam int B_PAUSE     = 11;

    // Word offsets of the register map
    localparam int OFS_STATUS  = 0;
    localparam int OFS_MASK    = 1;
    localparam int OFS_UNMASK  = 2;
    localparam int OFS_SETMASK = 3;
    localparam int OFS_SRC_CNT = 4;
    localparam int OFS_DST_CNT = 5;
    localparam int NUM_REGS    = 6;

    localparam logic [STAT_W-1:0] MASK_RESET = '1;
endpackage

// File: rtl/irq_status_bits.sv
// Sticky status register. Each bit is set by its set_vec bit and cleared by
// its clr_vec bit; when both hit one bit in the same cycle the set wins.
// Assumes set_vec and clr_vec are single-cycle qualified pulses.
module irq_status_bits #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] status
);
    // Update sticky bits: clear first, then OR in new events
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/irq_mask_bits.sv
// Mask register changed only by an unmask strobe (clears bits) and a
// mask strobe (sets bits). Assumes the two strobes never come together.
module irq_mask_bits #(
    parameter int           W     = 12,
    parameter logic [W-1:0] RESET = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] unmask_vec,
    input  logic [W-1:0] mask_vec,
    output logic [W-1:0] mask
);
    // Apply strobe vectors to the held mask
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= RESET;
        else        mask <= (mask & ~unmask_vec) | mask_vec;
    end
endmodule

// File: rtl/dscr_done_counter.sv
// Completion counter with clear-on-read. A read clear and an increment in
// the same cycle leave the counter at 1. wrap pulses (combinationally) in
// the cycle an increment takes the counter from all-ones to zero.
module dscr_done_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          rd_clr,
    output logic [CW-1:0] count,
    output logic          wrap
);
    localparam logic [CW-1:0] ONE = CW'(1);

    // Detect the all-ones to zero step of an uncleared increment
    always_comb wrap = inc && !rd_clr && (count == '1);

    // Count completions, zero on read
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (rd_clr) count <= inc ? ONE : '0;
        else if (inc)    count <= count + ONE;
    end
endmodule

// File: rtl/irq_acct_regs.sv
// Per-channel interrupt status, mask and completion accounting registers.
// Decodes a word-addressed register port, latches hardware events, keeps
// the mask through unmask/mask strobes and drives one level interrupt.
// Assumes ADDR_W >= 3 and DATA_W >= 12; read data is registered.
module irq_acct_regs
    import irq_acct_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_pause,
    input  logic              ev_xfer_done,
    input  logic              ev_wr_data_err,
    input  logic              ev_rd_data_err,
    input  logic              ev_dst_dscr_err,
    input  logic              ev_src_dscr_err,
    input  logic              ev_byte_ovf,
    input  logic              ev_src_dscr_done,
    input  logic              ev_dst_dscr_done,
    output logic              irq
);
    localparam int NSIDE = 2;

    logic              wr_acc, rd_acc, mapped;
    logic              hit_status, hit_unmask, hit_setmask;
    logic              hit_cnt  [NSIDE];
    logic [STAT_W-1:0] wbits, set_vec, clr_vec, unmask_vec, mask_vec;
    logic [STAT_W-1:0] status_q, mask_q;
    logic [CNT_W-1:0]  cnt_q    [NSIDE];
    logic              cnt_inc  [NSIDE];
    logic              cnt_wrap [NSIDE];
    logic [DATA_W-1:0] rd_mux;

    // Address decode of the access in this cycle
    always_comb begin
        wr_acc      = reg_sel && reg_we;
        rd_acc      = reg_sel && !reg_we;
        mapped      = (int'(reg_addr) < NUM_REGS);
        hit_status  = (int'(reg_addr) == OFS_STATUS);
        hit_unmask  = (int'(reg_addr) == OFS_UNMASK);
        hit_setmask = (int'(reg_addr) == OFS_SETMASK);
        hit_cnt[0]  = (int'(reg_addr) == OFS_SRC_CNT);
        hit_cnt[1]  = (int'(reg_addr) == OFS_DST_CNT);
        wbits       = reg_wdata[STAT_W-1:0];
    end

    // Source side is index 0, destination side index 1
    assign cnt_inc[0] = ev_src_dscr_done;
    assign cnt_inc[1] = ev_dst_dscr_done;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        dscr_done_counter #(.CW(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (cnt_inc[s]),
            .rd_clr (rd_acc && hit_cnt[s]),
            .count  (cnt_q[s]),
            .wrap   (cnt_wrap[s])
        );
    end

    // Gather hardware events and software clear/strobe vectors
    always_comb begin
        set_vec              = '0;
        set_vec[B_PAUSE]     = ev_pause;
        set_vec[B_XFER_DONE] = ev_xfer_done;
        set_vec[B_WR_DATA]   = ev_wr_data_err;
        set_vec[B_RD_DATA]   = ev_rd_data_err;
        set_vec[B_DST_DRD]   = ev_dst_dscr_err;
        set_vec[B_SRC_DRD]   = ev_src_dscr_err;
        set_vec[B_BYTE_OVF]  = ev_byte_ovf;
        set_vec[B_SRC_DONE]  = ev_src_dscr_done;
        set_vec[B_DST_DONE]  = ev_dst_dscr_done;
        set_vec[B_SRC_ACCT]  = cnt_wrap[0];
        set_vec[B_DST_ACCT]  = cnt_wrap[1];
        set_vec[B_INVALID]   = reg_sel && !mapped;
        clr_vec    = (wr_acc && hit_status)  ? wbits : '0;
        unmask_vec = (wr_acc && hit_unmask)  ? wbits : '0;
        mask_vec   = (wr_acc && hit_setmask) ? wbits : '0;
    end

    irq_status_bits #(.W(STAT_W)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .status  (status_q)
    );

    irq_mask_bits #(.W(STAT_W), .RESET(MASK_RESET)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .unmask_vec (unmask_vec),
        .mask_vec   (mask_vec),
        .mask       (mask_q)
    );

    // Select read data; strobes and unmapped offsets return zero
    always_comb begin
        rd_mux = '0;
        if (hit_status)      rd_mux[STAT_W-1:0] = status_q;
        else if (int'(reg_addr) == OFS_MASK) rd_mux[STAT_W-1:0] = mask_q;
        else if (hit_cnt[0]) rd_mux[CNT_W-1:0]  = cnt_q[0];
        else if (hit_cnt[1]) rd_mux[CNT_W-1:0]  = cnt_q[1];
    end

    // Register read data on each accepted read
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (rd_acc) reg_rdata <= rd_mux;
    end

    // Level interrupt from unmasked pending bits
    assign irq = |(status_q & ~mask_q);
endmodule

// File: rtl/irq_acct_regs_chk.sv
// Checker for irq_acct_regs: observes the register port, event inputs and
// the held status, mask and counter state. Attached by bind below.
module irq_acct_regs_chk
    import irq_acct_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_sel,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [STAT_W-1:0] wbits,
    input logic              ev_pause,
    input logic              ev_src_dscr_done,
    input logic [STAT_W-1:0] status,
    input logic [STAT_W-1:0] mask,
    input logic [CNT_W-1:0]  src_cnt,
    input logic              irq
);
    logic strobe_wr, src_rd;
    assign strobe_wr = reg_sel && reg_we &&
                       (int'(reg_addr) == OFS_UNMASK || int'(reg_addr) == OFS_SETMASK);
    assign src_rd    = reg_sel && !reg_we && (int'(reg_addr) == OFS_SRC_CNT);

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_wr |=> $stable(mask));

    p_unmask_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_we && int'(reg_addr) == OFS_UNMASK)
        |=> ((mask & $past(wbits)) == '0));

    p_irq_needs_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_src_dscr_done && !src_rd && src_cnt == '1)
        |=> (status[B_SRC_ACCT] && src_cnt == '0));

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd && !ev_src_dscr_done) |=> (src_cnt == '0));

    p_invalid_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && int'(reg_addr) >= NUM_REGS) |=> status[B_INVALID]);

    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pause |=> status[B_PAUSE]);
endmodule

bind irq_acct_regs irq_acct_regs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .reg_sel          (reg_sel),
    .reg_we           (reg_we),
    .reg_addr         (reg_addr),
    .wbits            (reg_wdata[11:0]),
    .ev_pause         (ev_pause),
    .ev_src_dscr_done (ev_src_dscr_done),
    .status           (status_q),
    .mask             (mask_q),
    .src_cnt          (cnt_q[0]),
    .irq              (irq)
);

// File: tb/irq_acct_regs_test.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected values, a monitor compares
// registered read data after each accepted read.
module irq_acct_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic ev_pause = 0, ev_xfer_done = 0, ev_wr_data_err = 0, ev_rd_data_err = 0;
    logic ev_dst_dscr_err = 0, ev_src_dscr_err = 0, ev_byte_ovf = 0;
    logic ev_src_dscr_done = 0, ev_dst_dscr_done = 0;
    logic irq;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    irq_acct_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_pause(ev_pause), .ev_xfer_done(ev_xfer_done),
        .ev_wr_data_err(ev_wr_data_err), .ev_rd_data_err(ev_rd_data_err),
        .ev_dst_dscr_err(ev_dst_dscr_err), .ev_src_dscr_err(ev_src_dscr_err),
        .ev_byte_ovf(ev_byte_ovf), .ev_src_dscr_done(ev_src_dscr_done),
        .ev_dst_dscr_done(ev_dst_dscr_done), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: note accepted reads, compare at the following falling edge
    always @(posedge clk) rd_seen <= rst_n && reg_sel && !reg_we;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) check("scoreboard underflow", 32'h1, 32'h0);
            else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 0; reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        reg_sel = 1; reg_we = 0; reg_addr = a;
        @(negedge clk);
        reg_sel = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        rd(0, 32'h000, "R1 status reset");
        rd(1, 32'hFFF, "R1 mask reset");
        rd(4, 32'h0, "R1 src count reset");
        rd(5, 32'h0, "R1 dst count reset");
        // R3 direct mask write ignored
        wr(1, 32'h0);
        rd(1, 32'hFFF, "R3 mask after direct write");
        // R10 transfer done event, masked so no irq (R5)
        ev_xfer_done = 1; @(negedge clk); ev_xfer_done = 0;
        rd(0, 32'h400, "R10 done bit 10");
        check("R5 irq masked", {31'd0, irq}, 32'd0);
        // R4 unmask strobe, R5 irq rises
        wr(2, 32'h400);
        check("R5 irq unmasked", {31'd0, irq}, 32'd1);
        rd(1, 32'hBFF, "R4 mask after unmask");
        rd(2, 32'h0, "R4 unmask reads zero");
        rd(3, 32'h0, "R4 setmask reads zero");
        // R2 write-one-to-clear
        wr(0, 32'h000);
        rd(0, 32'h400, "R2 zero write keeps bit");
        wr(0, 32'h400);
        check("R5 irq after clear", {31'd0, irq}, 32'd0);
        rd(0, 32'h000, "R2 one write clears bit");
        wr(3, 32'h400);
        rd(1, 32'hFFF, "R4 mask after setmask");
        // R6/R7 source completions
        ev_src_dscr_done = 1; repeat (3) @(negedge clk); ev_src_dscr_done = 0;
        rd(0, 32'h002, "R6 src done bit");
        rd(4, 32'h3, "R7 src count value");
        rd(4, 32'h0, "R7 src count cleared");
        // R6 destination wrap
        ev_dst_dscr_done = 1; repeat (256) @(negedge clk); ev_dst_dscr_done = 0;
        rd(0, 32'h026, "R6 dst done and acct error");
        rd(5, 32'h0, "R6 dst count wrapped");
        wr(0, 32'hFFF);
        // R8 unmapped offsets
        rd(6, 32'h0, "R8 unmapped read zero");
        rd(0, 32'h001, "R8 invalid flag on read");
        wr(0, 32'h001);
        wr(7, 32'hFFF);
        rd(0, 32'h001, "R8 invalid flag on write");
        rd(1, 32'hFFF, "R8 write had no effect on mask");
        // R9 event beats clear
        wr(0, 32'hFFF);
        ev_pause = 1; wr(0, 32'h800); ev_pause = 0;
        rd(0, 32'h800, "R9 set wins over clear");
        // R7 read and increment together
        ev_src_dscr_done = 1; repeat (2) @(negedge clk);
        rd(4, 32'h2, "R7 read with increment returns old");
        ev_src_dscr_done = 0;
        rd(4, 32'h1, "R7 counter left at one");
        // R10 remaining event bits
        wr(0, 32'hFFF);
        ev_pause = 1; ev_xfer_done = 1; ev_wr_data_err = 1; ev_rd_data_err = 1;
        ev_dst_dscr_err = 1; ev_src_dscr_err = 1; ev_byte_ovf = 1;
        @(negedge clk);
        ev_pause = 0; ev_xfer_done = 0; ev_wr_data_err = 0; ev_rd_data_err = 0;
        ev_dst_dscr_err = 0; ev_src_dscr_err = 0; ev_byte_ovf = 0;
        rd(0, 32'hFC8, "R10 event bit map");
        // R11 read data holds across idle cycles
        repeat (3) @(negedge clk);
        check("R11 rdata held", reg_rdata, 32'hFC8);
        // R5 single unmasked bit
        wr(2, 32'h008);
        check("R5 irq from bit 3", {31'd0, irq}, 32'd1);
        wr(0, 32'h008);
        check("R5 irq after bit 3 clear", {31'd0, irq}, 32'd0);
        @(negedge clk);
        if (exp_q.size() != 0) check("R11 pending reads", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule